// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor general-purpose parallel I/O through three byte-wide ports, A, B and C. Port C is split into an upper and a lower nibble. Each nibble is configured on its own, and both are read and written together at one address. A host bus selects one of four locations with two address bits. It has a chip select, read and write strobes that last one clock, and an 8-bit write and read path. A write-only control location holds the configuration of the two port groups. The same location also takes single-bit set and clear commands for the port C latch.

Each group can run in one of two modes. In simple mode, an output port holds the last value written and drives it. An input port returns the live pin values. In strobed mode, a port exchanges bytes with a peripheral through handshake lines taken from port C, and it raises an interrupt request line. Group A takes its lines from the upper nibble plus bit 3. Group B takes its lines from bits 0 to 2. Any bit of port C that a handshake does not use keeps the direction of its nibble.

The host bus is a plain register interface and never applies back-pressure. An access takes effect in the cycle in which `cs` and the strobe are both high. Read data is combinational during that cycle, and any side effect of the read happens at the closing clock edge. Pins are sampled on the clock and are assumed to be synchronous to it.

Top module: `pport_top`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control location. A read at address 3 returns 8'h00.
- R2: After reset, every port is an input in simple mode. `pa_oe`, `pb_oe` and `pc_oe` are 0, and all latches read as zero.
- R3: A control write with bit 7 = 1 sets the configuration from these fields: bits 6:5 (00 = group A simple, any other value = strobed), bit 4 (port A input), bit 3 (upper nibble input), bit 2 (group B strobed), bit 1 (port B input) and bit 0 (lower nibble input). An output direction drives every bit of that port or nibble.
- R4: A control write with bits 7:4 = 0000 changes only the port C latch bit indexed by bits 3:1, setting it to bit 0. A write with bit 7 = 0 and any of bits 6:4 set changes nothing.
- R5: A control write with bit 7 = 1 clears the port A, B and C output latches, the input latches, every buffer-full flag and every interrupt request.
- R6: In simple mode, a written output byte is driven and held until the next write. An input read returns the pins as they are in the read cycle.
- R7: In simple mode, each nibble of port C has its own direction. A port C read returns the pins for input bits and the latch for output bits.
- R8: For a strobed input port, every cycle in which its strobe is low (A: C4, B: C2) latches the port pins and sets input-full (A: C5, B: C1, high means full). A port read returns the latched byte, not the live pins.
- R9: For a strobed input port, a rising strobe sets the interrupt request (A: C3, B: C0) if the enable is 1 (A: latch bit C4, B: latch bit C2). A read of the port clears the request and input-full.
- R10: For a strobed output port, a write sets output-full and clears the request. Output-full shows on A: C7, B: C1, where low means full. A falling acknowledge (A: C6, B: C2) clears output-full. A rising acknowledge sets the request if the enable is 1 (A: latch bit C6, B: latch bit C2).
- R11: In strobed mode, handshake output bits are driven (`pc_oe` = 1) and handshake input bits are not driven. A port C read returns the current status values on the handshake output bits.
- R12: With `cs` low, reads return 8'h00 and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| addr | input | 2 | Location select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A drive enables |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B drive enables |
| pc_in | input | 8 | Port C pins in, including strobe and acknowledge |
| pc_out | output | 8 | Port C output values, including status lines |
| pc_oe | output | 8 | Port C drive enables |

## Verification
The hardest state to reach from the ports is a raised interrupt request. Getting there takes a mode write, then a separate single-bit command to set the enable latch, then a full low-then-high cycle on the strobe or acknowledge pin. A mode write in between, or a host read or write of that port, clears the request again. The stimulus walks through each strobed mode in that order. It also changes the port pins while a strobe is held low, checks that the byte latched last is the one read back, and repeats the strobe with the enable cleared. A reference model that runs every cycle compares every output pin, so status lines that change one cycle after a pin edge are checked in the right cycle.

// File: rtl/pport_pkg.sv
`timescale 1ns/1ps
package pport_pkg;
  localparam int PW = 8;
  localparam int HW = PW / 2;
  localparam int IW = $clog2(PW);

  typedef enum logic [1:0] {SEL_A = 2'd0, SEL_B = 2'd1, SEL_C = 2'd2, SEL_CTL = 2'd3} sel_e;

  typedef struct packed {
    logic a_strb;
    logic a_in;
    logic cu_in;
    logic b_strb;
    logic b_in;
    logic cl_in;
  } cfg_t;

  localparam cfg_t CFG_RST = '{a_strb: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                               b_strb: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  // port C roles in strobed mode
  localparam int C_INTR_B = 0;
  localparam int C_FLAG_B = 1;
  localparam int C_HS_B   = 2;
  localparam int C_INTR_A = 3;
  localparam int C_STB_A  = 4;
  localparam int C_IBF_A  = 5;
  localparam int C_ACK_A  = 6;
  localparam int C_OBF_A  = 7;
endpackage

// File: rtl/pport_ctl.sv
`timescale 1ns/1ps
module pport_ctl
  import pport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic          wr_pc,
  input  logic [PW-1:0] wdata,
  output cfg_t          cfg,
  output logic          mode_clr,
  output logic [PW-1:0] pc_lat
);
  logic          bit_cmd;
  logic [IW-1:0] bit_idx;

  assign mode_clr = wr_ctl & wdata[7];
  assign bit_cmd  = wr_ctl & (wdata[7:4] == 4'b0000);
  assign bit_idx  = wdata[IW:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RST;
      pc_lat <= '0;
    end else if (mode_clr) begin
      cfg.a_strb <= wdata[6] | wdata[5];
      cfg.a_in   <= wdata[4];
      cfg.cu_in  <= wdata[3];
      cfg.b_strb <= wdata[2];
      cfg.b_in   <= wdata[1];
      cfg.cl_in  <= wdata[0];
      pc_lat     <= '0;
    end else if (wr_pc) begin
      pc_lat <= wdata;
    end else if (bit_cmd) begin
      pc_lat[bit_idx] <= wdata[0];
    end
  end
endmodule

// File: rtl/pport_group.sv
`timescale 1ns/1ps
module pport_group
  import pport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          strobed,
  input  logic          is_in,
  input  logic [PW-1:0] pin,
  input  logic          wr_hit,
  input  logic          rd_hit,
  input  logic [PW-1:0] wdata,
  input  logic          hs_n,
  input  logic          inte,
  output logic [PW-1:0] out_lat,
  output logic          flag,
  output logic          intr,
  output logic [PW-1:0] rd_val
);
  logic [PW-1:0] in_lat;
  logic hs_q, hs_rise, hs_fall, strb_in, strb_out;

  assign hs_rise  = ~hs_q & hs_n;
  assign hs_fall  = hs_q & ~hs_n;
  assign strb_in  = strobed & is_in;
  assign strb_out = strobed & ~is_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_q <= 1'b1;
    else        hs_q <= hs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_lat <= '0;
    else if (clr)    out_lat <= '0;
    else if (wr_hit) out_lat <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                in_lat <= '0;
    else if (clr)              in_lat <= '0;
    else if (strb_in && !hs_n) in_lat <= pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      intr <= 1'b0;
    end else if (clr) begin
      flag <= 1'b0;
      intr <= 1'b0;
    end else if (strb_in) begin
      if (!hs_n)       flag <= 1'b1;
      else if (rd_hit) flag <= 1'b0;
      if (rd_hit)                 intr <= 1'b0;
      else if (hs_rise && inte)   intr <= 1'b1;
    end else if (strb_out) begin
      if (wr_hit)       flag <= 1'b1;
      else if (hs_fall) flag <= 1'b0;
      if (wr_hit)               intr <= 1'b0;
      else if (hs_rise && inte) intr <= 1'b1;
    end
  end

  always_comb begin
    if (!is_in)       rd_val = out_lat;
    else if (strobed) rd_val = in_lat;
    else              rd_val = pin;
  end
endmodule

// File: rtl/pport_portc.sv
`timescale 1ns/1ps
module pport_portc
  import pport_pkg::*;
(
  input  cfg_t          cfg,
  input  logic [PW-1:0] pc_lat,
  input  logic [PW-1:0] pc_in,
  input  logic          flag_a,
  input  logic          intr_a,
  input  logic          flag_b,
  input  logic          intr_b,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe,
  output logic          hs_a_n,
  output logic          hs_b_n,
  output logic          inte_a,
  output logic          inte_b,
  output logic [PW-1:0] rd_val
);
  always_comb begin
    for (int i = 0; i < PW; i++) begin
      pc_out[i] = pc_lat[i];
      pc_oe[i]  = (i < HW) ? ~cfg.cl_in : ~cfg.cu_in;
    end
    if (cfg.b_strb) begin
      pc_out[C_INTR_B] = intr_b;
      pc_oe[C_INTR_B]  = 1'b1;
      pc_out[C_FLAG_B] = cfg.b_in ? flag_b : ~flag_b;
      pc_oe[C_FLAG_B]  = 1'b1;
      pc_oe[C_HS_B]    = 1'b0;
    end
    if (cfg.a_strb) begin
      pc_out[C_INTR_A] = intr_a;
      pc_oe[C_INTR_A]  = 1'b1;
      if (cfg.a_in) begin
        pc_oe[C_STB_A]  = 1'b0;
        pc_out[C_IBF_A] = flag_a;
        pc_oe[C_IBF_A]  = 1'b1;
      end else begin
        pc_oe[C_ACK_A]  = 1'b0;
        pc_out[C_OBF_A] = ~flag_a;
        pc_oe[C_OBF_A]  = 1'b1;
      end
    end
  end

  assign hs_a_n = cfg.a_in ? pc_in[C_STB_A] : pc_in[C_ACK_A];
  assign inte_a = cfg.a_in ? pc_lat[C_STB_A] : pc_lat[C_ACK_A];
  assign hs_b_n = pc_in[C_HS_B];
  assign inte_b = pc_lat[C_HS_B];

  generate
    for (genvar k = 0; k < PW; k++) begin : g_rd
      assign rd_val[k] = pc_oe[k] ? pc_out[k] : pc_in[k];
    end
  endgenerate
endmodule

// File: rtl/pport_top.sv
`timescale 1ns/1ps
module pport_top
  import pport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  localparam int NG = 2;

  cfg_t          cfg;
  logic          mode_clr;
  logic [PW-1:0] pc_lat, pc_rd, rd_mux;
  logic          wr_en, rd_en;
  logic          hs_a_n, hs_b_n, inte_a, inte_b;

  logic [NG-1:0]         g_strb, g_in, g_hs_n, g_inte, g_wr, g_rd, g_flag, g_intr;
  logic [NG-1:0][PW-1:0] g_pin, g_out, g_rdv;

  assign wr_en = cs & wr;
  assign rd_en = cs & rd;

  pport_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctl   (wr_en && addr == SEL_CTL),
    .wr_pc    (wr_en && addr == SEL_C),
    .wdata    (wdata),
    .cfg      (cfg),
    .mode_clr (mode_clr),
    .pc_lat   (pc_lat)
  );

  assign g_strb = {cfg.b_strb, cfg.a_strb};
  assign g_in   = {cfg.b_in, cfg.a_in};
  assign g_hs_n = {hs_b_n, hs_a_n};
  assign g_inte = {inte_b, inte_a};
  assign g_pin  = {pb_in, pa_in};

  generate
    for (genvar g = 0; g < NG; g++) begin : g_grp
      assign g_wr[g] = wr_en && (addr == 2'(g));
      assign g_rd[g] = rd_en && (addr == 2'(g));
      pport_group u_grp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_clr),
        .strobed (g_strb[g]),
        .is_in   (g_in[g]),
        .pin     (g_pin[g]),
        .wr_hit  (g_wr[g]),
        .rd_hit  (g_rd[g]),
        .wdata   (wdata),
        .hs_n    (g_hs_n[g]),
        .inte    (g_inte[g]),
        .out_lat (g_out[g]),
        .flag    (g_flag[g]),
        .intr    (g_intr[g]),
        .rd_val  (g_rdv[g])
      );
    end
  endgenerate

  pport_portc u_pc (
    .cfg    (cfg),
    .pc_lat (pc_lat),
    .pc_in  (pc_in),
    .flag_a (g_flag[0]),
    .intr_a (g_intr[0]),
    .flag_b (g_flag[1]),
    .intr_b (g_intr[1]),
    .pc_out (pc_out),
    .pc_oe  (pc_oe),
    .hs_a_n (hs_a_n),
    .hs_b_n (hs_b_n),
    .inte_a (inte_a),
    .inte_b (inte_b),
    .rd_val (pc_rd)
  );

  assign pa_out = g_out[0];
  assign pb_out = g_out[1];
  assign pa_oe  = {PW{~cfg.a_in}};
  assign pb_oe  = {PW{~cfg.b_in}};

  always_comb begin
    case (addr)
      SEL_A:   rd_mux = g_rdv[0];
      SEL_B:   rd_mux = g_rdv[1];
      SEL_C:   rd_mux = pc_rd;
      default: rd_mux = '0;
    endcase
  end

  assign rdata = rd_en ? rd_mux : '0;
endmodule

// File: rtl/pport_sva.sv
`timescale 1ns/1ps
module pport_sva
  import pport_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic [1:0]    addr,
  input logic [PW-1:0] wdata,
  input logic [PW-1:0] rdata,
  input logic [PW-1:0] pa_in,
  input logic [PW-1:0] pa_out,
  input logic [PW-1:0] pb_out,
  input logic [PW-1:0] pc_in,
  input logic [PW-1:0] pc_out,
  input logic [PW-1:0] pc_oe,
  input cfg_t          cfg,
  input logic [PW-1:0] pc_lat
);
  AST_CTL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == 2'd3) |-> rdata == '0);  // R1

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'd3 && wdata[7]) |=> (pa_out == '0 && pb_out == '0 && pc_lat == '0));  // R5

  AST_BIT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'd3 && wdata[7:4] == 4'b0000) |=> pc_lat[$past(wdata[3:1])] == $past(wdata[0]));  // R4

  AST_SIMPLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == 2'd0 && !cfg.a_strb && cfg.a_in) |-> rdata == pa_in);  // R6

  AST_IBF_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.a_strb && cfg.a_in && !pc_in[4] && !(cs && wr && addr == 2'd3)) |=> pc_out[5]);  // R8

  AST_OBF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.a_strb && !cfg.a_in && cs && wr && addr == 2'd0) |=> !pc_out[7]);  // R10

  AST_HS_DIR_B: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.b_strb |-> (pc_oe[1:0] == 2'b11 && !pc_oe[2]));  // R11

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> rdata == '0);  // R12
endmodule

bind pport_top pport_sva u_sva (.*);

// File: tb/pport_top_bench.sv
`timescale 1ns/1ps
module pport_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int    vecs = 0, miss = 0;
  string req = "R2";
  bit    started = 1'b0;

  always #4 clk = ~clk;

  pport_top u_pport_top (.*);

  // reference model state
  bit       m_astr, m_ain, m_cuin, m_bstr, m_bin, m_clin;
  bit [7:0] m_out[2], m_inl[2], m_pcl;
  bit       m_flag[2], m_intr[2], m_hsq[2];

  function automatic bit hs_pin(int g);
    if (g == 0) return m_ain ? pc_in[4] : pc_in[6];
    return pc_in[2];
  endfunction

  function automatic bit inte(int g);
    if (g == 0) return m_ain ? m_pcl[4] : m_pcl[6];
    return m_pcl[2];
  endfunction

  task automatic m_clear();
    for (int g = 0; g < 2; g++) begin
      m_out[g] = 0; m_inl[g] = 0; m_flag[g] = 0; m_intr[g] = 0;
    end
    m_pcl = 0;
  endtask

  task automatic m_reset();
    {m_astr, m_ain, m_cuin, m_bstr, m_bin, m_clin} = 6'b011011;
    m_clear();
    m_hsq[0] = 1; m_hsq[1] = 1;
  endtask

  task automatic m_step();
    bit nh[2];
    for (int g = 0; g < 2; g++) begin
      bit strb, isin, w, r, h, e;
      bit [7:0] pin;
      strb = (g == 0) ? m_astr : m_bstr;
      isin = (g == 0) ? m_ain : m_bin;
      pin  = (g == 0) ? pa_in : pb_in;
      w = cs && wr && addr == 2'(g);
      r = cs && rd && addr == 2'(g);
      h = hs_pin(g);
      e = inte(g);
      if (w) m_out[g] = wdata;
      if (strb && isin) begin
        if (!h) begin m_inl[g] = pin; m_flag[g] = 1; end
        else if (r) m_flag[g] = 0;
        if (r) m_intr[g] = 0;
        else if (h && !m_hsq[g] && e) m_intr[g] = 1;
      end else if (strb) begin
        if (w) m_flag[g] = 1;
        else if (!h && m_hsq[g]) m_flag[g] = 0;
        if (w) m_intr[g] = 0;
        else if (h && !m_hsq[g] && e) m_intr[g] = 1;
      end
      nh[g] = h;
    end
    m_hsq[0] = nh[0]; m_hsq[1] = nh[1];
    if (cs && wr && addr == 2'd3) begin
      if (wdata[7]) begin
        m_astr = wdata[6] | wdata[5]; m_ain = wdata[4]; m_cuin = wdata[3];
        m_bstr = wdata[2]; m_bin = wdata[1]; m_clin = wdata[0];
        m_clear();
      end else if (wdata[6:4] == 3'b000) begin
        m_pcl[wdata[3:1]] = wdata[0];
      end
    end else if (cs && wr && addr == 2'd2) begin
      m_pcl = wdata;
    end
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic exp_pc(output bit [7:0] o, output bit [7:0] oe);
    for (int i = 0; i < 8; i++) begin
      o[i]  = m_pcl[i];
      oe[i] = (i < 4) ? !m_clin : !m_cuin;
    end
    if (m_bstr) begin
      o[0] = m_intr[1]; oe[0] = 1;
      o[1] = m_bin ? m_flag[1] : !m_flag[1]; oe[1] = 1;
      oe[2] = 0;
    end
    if (m_astr) begin
      o[3] = m_intr[0]; oe[3] = 1;
      if (m_ain) begin oe[4] = 0; o[5] = m_flag[0]; oe[5] = 1; end
      else begin oe[6] = 0; o[7] = !m_flag[0]; oe[7] = 1; end
    end
  endtask

  task automatic chk(input string nm, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s act=%h exp=%h", req, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      bit [7:0] eo, eoe, er;
      #2;
      exp_pc(eo, eoe);
      er = 8'h00;
      if (cs && rd) begin
        case (addr)
          2'd0: er = m_ain ? (m_astr ? m_inl[0] : pa_in) : m_out[0];
          2'd1: er = m_bin ? (m_bstr ? m_inl[1] : pb_in) : m_out[1];
          2'd2: for (int i = 0; i < 8; i++) er[i] = eoe[i] ? eo[i] : pc_in[i];
          default: er = 8'h00;
        endcase
      end
      chk("pa_out", pa_out, m_out[0]);
      chk("pa_oe", pa_oe, {8{!m_ain}});
      chk("pb_out", pb_out, m_out[1]);
      chk("pb_oe", pb_oe, {8{!m_bin}});
      chk("pc_out", pc_out, eo);
      chk("pc_oe", pc_oe, eoe);
      chk("rdata", rdata, er);
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; wr = 1'b1; rd = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; rd = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    miss++;
    $display("FAIL %s watchdog act=running exp=done", req);
    finish_run();
  end

  initial begin
    m_reset();
    req = "R2";
    idle(3);
    rst_n = 1'b1;
    idle(2);

    req = "R3";
    bus_wr(3, 8'h81); idle(1);
    bus_wr(3, 8'h9A); idle(1);

    req = "R6";
    bus_wr(3, 8'h80);
    bus_wr(0, 8'h5A); bus_wr(1, 8'hC3); idle(2);
    bus_rd(0); bus_rd(1);
    bus_wr(3, 8'h9B);
    @(negedge clk); pa_in = 8'h3C; bus_rd(0);
    @(negedge clk); pa_in = 8'hA5; bus_rd(0);
    @(negedge clk); pb_in = 8'h7E; bus_rd(1);

    req = "R1";
    bus_rd(3); bus_wr(1, 8'h24); bus_rd(2);

    req = "R7";
    bus_wr(3, 8'h88); bus_wr(2, 8'hA5);
    @(negedge clk); pc_in = 8'h3C; bus_rd(2);
    bus_wr(3, 8'h81); bus_wr(2, 8'h5A); bus_rd(2);

    req = "R4";
    bus_wr(3, 8'h0F); bus_wr(3, 8'h0A); bus_wr(3, 8'h4D); bus_wr(3, 8'h03);
    bus_rd(2);

    req = "R5";
    bus_wr(0, 8'hFF); bus_wr(1, 8'hEE); bus_wr(2, 8'hDD);
    bus_wr(3, 8'h80); idle(2);

    req = "R12";
    bus_rd(0, 1'b0); bus_wr(0, 8'h12, 1'b0); bus_wr(3, 8'h9B, 1'b0); idle(1); bus_rd(0);

    req = "R8";
    @(negedge clk); pc_in = 8'hFF;
    bus_wr(3, 8'hB3); bus_wr(3, 8'h09);
    @(negedge clk); pa_in = 8'h77; pc_in[4] = 1'b0;
    @(negedge clk); pa_in = 8'h66;
    @(negedge clk); pc_in[4] = 1'b1; pa_in = 8'h11;
    idle(2);
    req = "R9";
    bus_rd(0); idle(2);
    bus_wr(3, 8'h08);
    @(negedge clk); pc_in[4] = 1'b0;
    @(negedge clk); pc_in[4] = 1'b1;
    idle(1);
    req = "R11";
    bus_rd(2);
    req = "R9";
    bus_rd(0); idle(1);

    req = "R10";
    bus_wr(3, 8'hA3); bus_wr(3, 8'h0D);
    bus_wr(0, 8'h99); idle(2);
    @(negedge clk); pc_in[6] = 1'b0;
    idle(2);
    @(negedge clk); pc_in[6] = 1'b1;
    idle(2);
    req = "R11";
    bus_rd(2);
    req = "R10";
    bus_wr(0, 8'h44); idle(1);

    req = "R9";
    @(negedge clk); pc_in = 8'hFF;
    bus_wr(3, 8'h96); bus_wr(3, 8'h05);
    @(negedge clk); pb_in = 8'h5C; pc_in[2] = 1'b0;
    @(negedge clk); pc_in[2] = 1'b1; pb_in = 8'h00;
    idle(2);
    req = "R11";
    bus_rd(2);
    req = "R8";
    bus_rd(1); idle(1);

    req = "R10";
    bus_wr(3, 8'h94); bus_wr(3, 8'h05);
    bus_wr(1, 8'h3E); idle(1);
    @(negedge clk); pc_in[2] = 1'b0;
    idle(1);
    @(negedge clk); pc_in[2] = 1'b1;
    idle(2);
    req = "R11";
    bus_rd(2);
    bus_wr(3, 8'h80); idle(2);

    finish_run();
  end
endmodule